// File: doc/BRIEF.md
# Crystal Clock Divider with Glitch-Free Double-Speed Switch

This block makes the core and peripheral clock of an 8-bit controller core from the crystal input clock. In standard mode the core clock is the crystal divided by two, so a machine cycle takes twelve crystal periods. In double-speed mode the divider is bypassed and the core clock follows the crystal, so a machine cycle takes six crystal periods. Every time base that runs from this clock runs twice as fast in double-speed mode: timer periods halve and baud rates double.

Software requests a mode through a single level input. The block passes that bit through a synchronizer and applies it only on an edge where the free-running half-rate clock rises. At that edge both candidate clocks rise together, so the output never produces a runt pulse in either direction. A one-crystal-period machine-cycle strobe is emitted for the core. Its count restarts at the edge where a new mode takes effect. A separate output reports the mode that is actually in force, which lags the request.

Top module: `x2_clock_switch`

## Requirements
- R1: While reset is high the block is in standard mode: `x2_active` is 0, `mc_strobe` is 0 and `core_clk` is low, whatever `mode_req` holds.
- R2: In standard mode `core_clk` is the crystal divided by two. Counting crystal rising edges from 1 at the first edge after reset release, `core_clk` rises on odd-numbered edges and falls on even-numbered edges.
- R3: In double-speed mode (`x2_active` = 1) `core_clk` equals `clk`.
- R4: `mode_req` passes through `SYNC_STAGES` flip-flops. A new value takes effect only on an odd-numbered crystal edge, which is a rising edge of the half-rate clock. If the request changes just before edge k, the mode switches on edge k+`SYNC_STAGES`, or on the edge after it when that edge number is even.
- R5: Every high or low phase of `core_clk` lasts exactly half or exactly one crystal period, including the phases around a mode switch. No phase is ever shorter than half a crystal period.
- R6: In standard mode `mc_strobe` is high for one crystal period once every 2*`CORE_PER_MC` (12) crystal periods.
- R7: In double-speed mode `mc_strobe` is high for one crystal period once every `CORE_PER_MC` (6) crystal periods.
- R8: On the edge where a mode switch takes effect, `mc_strobe` is 0 and the machine-cycle count restarts. The first strobe in the new mode comes a full new-mode machine cycle after that edge. After reset release the first strobe comes 12 edges after release.
- R9: Between two consecutive strobes with no switch in between, `core_clk` has exactly `CORE_PER_MC` rising edges in either mode.
- R10: `x2_active` shows the mode in force (1 = double speed). Once the switch edge of R4 has passed, it equals the held `mode_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal input clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 1 | Requested mode from software, 1 = double speed, any clock domain |
| core_clk | output | 1 | Core and peripheral clock |
| mc_strobe | output | 1 | One-crystal-period pulse that marks the end of a machine cycle |
| x2_active | output | 1 | Mode currently in force, 1 = double speed |

## Verification
The bench toggles the request at both parities of the crystal edge count. This catches a design that switches on the falling half of the divider or skips the synchronizer: its switch lands one edge early or late and leaves a half-period runt on the core clock. The bench times every core clock phase, so it sees a runt as a phase shorter than half a crystal period. After each switch the bench requires the strobe to restart cleanly. A design that carried the old count over would give a short or long first machine cycle, and one that kept the old limit would give the wrong strobe spacing. A reset while in double-speed mode with the request still set checks that reset forces standard mode and that the request is honoured again only on the third edge.

// File: rtl/x2clk_pkg.sv
package x2clk_pkg;

  typedef enum logic {
    MODE_STD = 1'b0,
    MODE_X2  = 1'b1
  } clk_mode_e;

  // Machine-cycle length in crystal periods for a given mode.
  function automatic int unsigned mcycle_len(clk_mode_e m, int unsigned std_len,
                                             int unsigned x2_len);
    return (m == MODE_X2) ? x2_len : std_len;
  endfunction

endpackage

// File: rtl/x2clk_sync.sv
module x2clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/x2clk_mode_gate.sv
module x2clk_mode_gate
  import x2clk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_sync,
  output logic      half_clk,
  output clk_mode_e mode_eff,
  output logic      restart
);

  // The coming edge raises half_clk: the only edge where a switch is safe.
  logic      accept;
  clk_mode_e mode_new;

  always_comb begin
    accept   = ~half_clk;
    mode_new = clk_mode_e'(mode_sync);
    restart  = accept && (mode_new != mode_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_clk <= 1'b0;
      mode_eff <= MODE_STD;
    end else begin
      half_clk <= ~half_clk;
      if (accept) mode_eff <= mode_new;
    end
  end

endmodule

// File: rtl/x2clk_mcycle.sv
module x2clk_mcycle
  import x2clk_pkg::*;
#(
  parameter int STD_LEN = 12,
  parameter int X2_LEN  = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  clk_mode_e mode_eff,
  input  logic      restart,
  output logic      strobe
);

  localparam int MAX_LEN = (STD_LEN > X2_LEN) ? STD_LEN : X2_LEN;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb last = CW'(mcycle_len(mode_eff, STD_LEN, X2_LEN) - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt == last) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= 1'b0;
    end
  end

endmodule

// File: rtl/x2_clock_switch.sv
module x2_clock_switch
  import x2clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CORE_PER_MC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_req,
  output logic core_clk,
  output logic mc_strobe,
  output logic x2_active
);

  localparam int STD_LEN = 2 * CORE_PER_MC;
  localparam int X2_LEN  = CORE_PER_MC;

  logic      mode_sync;
  logic      half_clk;
  logic      restart;
  clk_mode_e mode_eff;

  x2clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mode_req),
    .q   (mode_sync)
  );

  x2clk_mode_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .mode_sync (mode_sync),
    .half_clk  (half_clk),
    .mode_eff  (mode_eff),
    .restart   (restart)
  );

  x2clk_mcycle #(.STD_LEN(STD_LEN), .X2_LEN(X2_LEN)) u_mcycle (
    .clk      (clk),
    .rst      (rst),
    .mode_eff (mode_eff),
    .restart  (restart),
    .strobe   (mc_strobe)
  );

  // Both mux inputs rise on the edge where mode_eff may change.
  always_comb begin
    x2_active = (mode_eff == MODE_X2);
    core_clk  = x2_active ? clk : half_clk;
  end

endmodule

// File: rtl/x2clk_checker.sv
module x2clk_checker (
  input logic clk,
  input logic rst,
  input logic core_clk,
  input logic mc_strobe,
  input logic x2_active
);

  logic rst_d = 1'b0;
  logic ph;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_state_chk: assert (!x2_active && !mc_strobe && !core_clk)
        else $error("reset state violated");
    end
  end

  // R4
  switch_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (x2_active != $past(x2_active)) |-> !$past(ph));

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    mc_strobe |=> !mc_strobe);

  // R8
  restart_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (x2_active != $past(x2_active)) |-> !mc_strobe);

  // R2
  std_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !x2_active && !$past(x2_active)) |-> (core_clk != $past(core_clk)));

endmodule

bind x2_clock_switch x2clk_checker u_x2clk_checker (
  .clk       (clk),
  .rst       (rst),
  .core_clk  (core_clk),
  .mc_strobe (mc_strobe),
  .x2_active (x2_active)
);

// File: tb/tb_x2_clock_switch.sv
`timescale 1ns/1ps
module tb_x2_clock_switch;

  localparam int SYNC = 2;
  localparam int CPM  = 6;
  localparam int STDL = 2 * CPM;
  localparam int X2L  = CPM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_req = 1'b0;
  logic core_clk, mc_strobe, x2_active;

  x2_clock_switch #(.SYNC_STAGES(SYNC), .CORE_PER_MC(CPM)) dut (
    .clk(clk), .rst(rst), .mode_req(mode_req),
    .core_clk(core_clk), .mc_strobe(mc_strobe), .x2_active(x2_active)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  int exp_edge = 0;
  int rises  = 0;
  logic rst_q = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Edge on which a request changed just before edge n+1 takes effect.
  function automatic int switch_edge(input int cur_n);
    int e;
    e = cur_n + 1 + SYNC;
    if (e % 2 == 0) e++;
    return e;
  endfunction

  always @(posedge clk) begin
    rst_q <= rst;
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  always @(posedge core_clk) rises++;

  // Phase widths of core_clk (R5)
  bit     have_last = 1'b0;
  longint last_t = 0;
  always @(core_clk) begin
    if (rst || rst_q) begin
      have_last = 1'b0;
    end else begin
      if (have_last) begin
        longint w;
        w = longint'($time) - last_t;
        chk(w >= 5, "R5", "phase shorter than half crystal period", w, 5);
        chk(w == 5 || w == 10, "R5", "phase width", w, 10);
      end
      have_last = 1'b1;
      last_t = longint'($time);
    end
  end

  // Output monitor, sampled on the falling crystal edge
  logic prev_x2 = 1'b0;
  int   gap = 0;
  int   rise_base = 0;
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      chk(x2_active == 1'b0, "R1", "x2_active in reset", x2_active, 0);
      chk(mc_strobe == 1'b0, "R1", "mc_strobe in reset", mc_strobe, 0);
      chk(core_clk == 1'b0, "R1", "core_clk in reset", core_clk, 0);
      prev_x2 = 1'b0;
      gap = 0;
      rise_base = rises;
    end else if (rst_q === 1'b0) begin
      int lim;
      gap++;
      if (x2_active != prev_x2) begin
        chk(n == exp_edge, "R4", "switch edge", n, exp_edge);
        chk(n % 2 == 1, "R4", "switch edge parity", n % 2, 1);
        chk(x2_active == mode_req, "R10", "effective mode after switch", x2_active, mode_req);
        chk(mc_strobe == 1'b0, "R8", "strobe on switch edge", mc_strobe, 0);
        gap = 0;
        rise_base = rises;
      end else begin
        lim = x2_active ? X2L : STDL;
        if (mc_strobe) begin
          chk(gap == lim, x2_active ? "R7" : "R6", "strobe spacing", gap, lim);
          chk(rises - rise_base == CPM, "R9", "core edges per machine cycle",
              rises - rise_base, CPM);
          gap = 0;
          rise_base = rises;
        end else begin
          chk(gap < lim, x2_active ? "R7" : "R6", "missing strobe", gap, lim - 1);
        end
        if (n > exp_edge)
          chk(x2_active == mode_req, "R10", "effective mode lags request", x2_active, mode_req);
        if (x2_active) chk(core_clk == clk, "R3", "core_clk follows crystal", core_clk, clk);
        else           chk(core_clk == n[0], "R2", "divided clock phase", core_clk, n[0]);
      end
      prev_x2 = x2_active;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    exp_edge = switch_edge(0);
    rst = 1'b0;
    // Directed: switches requested at both edge parities
    repeat (40) @(negedge clk);
    exp_edge = switch_edge(n); mode_req = 1'b1;
    repeat (9) @(negedge clk);
    exp_edge = switch_edge(n); mode_req = 1'b0;
    repeat (8) @(negedge clk);
    exp_edge = switch_edge(n); mode_req = 1'b1;
    repeat (8) @(negedge clk);
    exp_edge = switch_edge(n); mode_req = 1'b0;
    repeat (30) @(negedge clk);
    // Random hold times
    for (int i = 0; i < 60; i++) begin
      int hold;
      hold = 8 + int'($urandom % 40);
      exp_edge = switch_edge(n);
      mode_req = ~mode_req;
      repeat (hold) @(negedge clk);
    end
    // R1: reset from double-speed mode with the request still set
    exp_edge = switch_edge(n); mode_req = 1'b1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    exp_edge = switch_edge(0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    finish_run();
  end

endmodule